// File: doc/BRIEF.md
# Four-Port Shared Memory with Per-Port Write Hold

This block is a synchronous 2048 x 8 memory with four ports that are fully independent. Each port has its own address, write data, active-low select, active-low write strobe, active-low output enable and active-low write hold, and no port ever waits on another. In a single clock cycle, all four ports may read or write any locations, including the same location.

The block does no arbitration. When a port reads a location that is being written in the same cycle, it gets the new data (write-first). When several unblocked ports write one location in the same cycle, the lowest-numbered port's data is the value kept. Each port that took part in such a same-address write raises a clash flag. Read data is registered, so a read result appears one cycle after the request. When a port's valid output is low, its data output is zero.

Top module: `quad_port_ram`

## Requirements
- R1: While reset is high and on the first cycle after it falls, every port_rvalid, port_clash and port_rdata bit is 0.
- R2: A port with port_sel_n=0, port_wr_n=0 and port_hold_n=1 stores port_wdata at port_addr on the rising edge. A later read of that address returns the stored value.
- R3: A port with port_hold_n=0 stores nothing. The addressed location keeps its previous value, and a read of it in the same cycle returns the old value.
- R4: A port with port_sel_n=0, port_wr_n=1 and port_oe_n=0 presents the stored word at port_rdata, with port_rvalid=1, one cycle after the request.
- R5: A port with port_sel_n=1, or with port_oe_n=1 while reading, shows port_rvalid=0 and port_rdata=0 in the next cycle. A deselected port never writes, whatever port_wr_n is.
- R6: A writing port (port_sel_n=0, port_wr_n=0) shows port_rvalid=0 and port_rdata=0 in the next cycle.
- R7: A read of an address that exactly one unblocked port writes in the same cycle returns that write data.
- R8: When several unblocked ports write one address in the same cycle, the lowest-numbered of them supplies both the stored value and any same-cycle read result.
- R9: In the cycle after a write, port_clash[p]=1 exactly when port p made an unblocked write to an address that at least one other unblocked port also wrote. Writes blocked by port_hold_n do not count.
- R10: Under mixed traffic on all four ports at once, every port's output matches the per-port rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| port_sel_n | input | 4 | Per-port select, low = active |
| port_wr_n | input | 4 | Per-port direction, low = write, high = read |
| port_oe_n | input | 4 | Per-port output enable, low = drive read data |
| port_hold_n | input | 4 | Per-port write hold, low = write blocked |
| port_addr | input | 4x11 | Per-port word address |
| port_wdata | input | 4x8 | Per-port write data |
| port_rdata | output | 4x8 | Per-port registered read data, 0 when not valid |
| port_rvalid | output | 4 | Per-port read-valid flag |
| port_clash | output | 4 | Per-port same-address write collision flag |

## Verification
The bench first writes every location through all four ports in a single pass and reads each one back. It then runs directed cycles that separate a held write from a real one, a deselected write strobe from a real write, a disabled output from a live read, a single forwarded write from a multi-writer clash, and a clash where one writer is held. After that come several thousand cycles of mixed operations spread over only twelve addresses, so that same-cycle overlaps and collisions happen often. Throughout, a behavioural memory model predicts every output on every cycle.

// File: rtl/qpr_pkg.sv
`timescale 1ns/1ps
package qpr_pkg;
  typedef struct packed {
    logic we;
    logic re;
  } port_op_t;
endpackage

// File: rtl/qpr_port_decode.sv
`timescale 1ns/1ps
module qpr_port_decode
  import qpr_pkg::*;
(
  input  logic     sel_n,
  input  logic     wr_n,
  input  logic     oe_n,
  input  logic     hold_n,
  output port_op_t op
);
  // write needs select, write strobe and no hold; read needs select and output enable
  assign op.we = ~sel_n & ~wr_n & hold_n;
  assign op.re = ~sel_n &  wr_n & ~oe_n;
endmodule

// File: rtl/qpr_write_resolve.sv
`timescale 1ns/1ps
module qpr_write_resolve #(
  parameter int N  = 4,
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic [N-1:0]         we,
  input  logic [N-1:0][AW-1:0] addr,
  input  logic [N-1:0][DW-1:0] wdata,
  output logic [N-1:0]         hit,
  output logic [N-1:0][DW-1:0] fdata,
  output logic [N-1:0]         clash
);
  // scan from the top port down so the lowest-numbered writer is taken last
  always_comb begin
    for (int p = 0; p < N; p++) begin
      hit[p]   = 1'b0;
      fdata[p] = '0;
      clash[p] = 1'b0;
      for (int q = N - 1; q >= 0; q--) begin
        if (we[q] && (addr[q] == addr[p])) begin
          hit[p]   = 1'b1;
          fdata[p] = wdata[q];
          if (q != p) clash[p] = we[p];
        end
      end
    end
  end
endmodule

// File: rtl/qpr_mem_core.sv
`timescale 1ns/1ps
module qpr_mem_core #(
  parameter int N  = 4,
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         we,
  input  logic [N-1:0]         re,
  input  logic [N-1:0][AW-1:0] addr,
  input  logic [N-1:0][DW-1:0] wdata,
  input  logic [N-1:0]         hit,
  input  logic [N-1:0][DW-1:0] fdata,
  input  logic [N-1:0]         clash,
  output logic [N-1:0][DW-1:0] rdata,
  output logic [N-1:0]         rvalid,
  output logic [N-1:0]         collide
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // later statements win, so port 0 is written last and prevails
  always_ff @(posedge clk) begin
    for (int q = N - 1; q >= 0; q--) begin
      if (we[q]) mem[addr[q]] <= wdata[q];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      rvalid  <= '0;
      collide <= '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        rvalid[p]  <= re[p];
        collide[p] <= clash[p];
        if (!re[p])     rdata[p] <= '0;
        else if (hit[p]) rdata[p] <= fdata[p];
        else             rdata[p] <= mem[addr[p]];
      end
    end
  end
endmodule

// File: rtl/quad_port_ram.sv
`timescale 1ns/1ps
module quad_port_ram
  import qpr_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         port_sel_n,
  input  logic [N-1:0]         port_wr_n,
  input  logic [N-1:0]         port_oe_n,
  input  logic [N-1:0]         port_hold_n,
  input  logic [N-1:0][AW-1:0] port_addr,
  input  logic [N-1:0][DW-1:0] port_wdata,
  output logic [N-1:0][DW-1:0] port_rdata,
  output logic [N-1:0]         port_rvalid,
  output logic [N-1:0]         port_clash
);
  port_op_t [N-1:0]    ops;
  logic [N-1:0]         we, re, hit, clash;
  logic [N-1:0][DW-1:0] fdata;

  for (genvar p = 0; p < N; p++) begin : g_port
    qpr_port_decode u_dec (
      .sel_n  (port_sel_n[p]),
      .wr_n   (port_wr_n[p]),
      .oe_n   (port_oe_n[p]),
      .hold_n (port_hold_n[p]),
      .op     (ops[p])
    );
    assign we[p] = ops[p].we;
    assign re[p] = ops[p].re;

    assert_deselect_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      $past(port_sel_n[p]) |-> (!port_rvalid[p] && !port_clash[p]));
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
      !port_rvalid[p] |-> (port_rdata[p] == '0));
    assert_writer_silent_R6: assert property (@(posedge clk) disable iff (rst)
      $past(!port_sel_n[p] && !port_wr_n[p]) |-> !port_rvalid[p]);
    assert_hold_no_clash_R3: assert property (@(posedge clk) disable iff (rst)
      $past(!port_hold_n[p]) |-> !port_clash[p]);
    assert_read_valid_R4: assert property (@(posedge clk) disable iff (rst)
      $past(!port_sel_n[p] && port_wr_n[p] && !port_oe_n[p]) |-> port_rvalid[p]);
  end

  assert_clash_pairs_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(port_clash) != 1);

  qpr_write_resolve #(.N(N), .AW(AW), .DW(DW)) u_res (
    .we    (we),
    .addr  (port_addr),
    .wdata (port_wdata),
    .hit   (hit),
    .fdata (fdata),
    .clash (clash)
  );

  qpr_mem_core #(.N(N), .AW(AW), .DW(DW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .re      (re),
    .addr    (port_addr),
    .wdata   (port_wdata),
    .hit     (hit),
    .fdata   (fdata),
    .clash   (clash),
    .rdata   (port_rdata),
    .rvalid  (port_rvalid),
    .collide (port_clash)
  );
endmodule

// File: tb/quad_port_ram_tb.sv
`timescale 1ns/1ps
module quad_port_ram_tb;
  localparam int N = 4, AW = 11, DW = 8, DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]         sel_n, wr_n, oe_n, hold_n;
  logic [N-1:0][AW-1:0] addr;
  logic [N-1:0][DW-1:0] wdata, rdata;
  logic [N-1:0]         rvalid, clash;

  quad_port_ram #(.N(N), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .port_sel_n(sel_n), .port_wr_n(wr_n), .port_oe_n(oe_n),
    .port_hold_n(hold_n), .port_addr(addr), .port_wdata(wdata),
    .port_rdata(rdata), .port_rvalid(rvalid), .port_clash(clash)
  );

  int    mem_m [DEPTH];
  int    errors = 0;
  int    checks = 0;
  string phase_tag = "R4";

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle_all();
    sel_n = '1; wr_n = '1; oe_n = '1; hold_n = '1; addr = '0; wdata = '0;
  endtask

  task automatic set_port(int p, bit s, bit w, bit o, bit h, int a, int d);
    sel_n[p] = s; wr_n[p] = w; oe_n[p] = o; hold_n[p] = h;
    addr[p] = AW'(a); wdata[p] = DW'(d);
  endtask

  task automatic cycle();
    int    e_data [N];
    bit    e_val  [N];
    bit    e_clash[N];
    string tg     [N];
    bit    we     [N];
    bit    re     [N];
    for (int p = 0; p < N; p++) begin
      we[p] = !sel_n[p] && !wr_n[p] && hold_n[p];
      re[p] = !sel_n[p] && wr_n[p] && !oe_n[p];
    end
    for (int p = 0; p < N; p++) begin
      int nw = 0;
      int fwd = 0;
      for (int q = 0; q < N; q++) begin
        if (we[q] && addr[q] == addr[p]) begin
          if (nw == 0) fwd = int'(wdata[q]);
          nw++;
        end
      end
      e_val[p]   = re[p];
      e_clash[p] = we[p] && (nw > 1);
      e_data[p]  = 0;
      if (re[p]) begin
        e_data[p] = (nw > 0) ? fwd : mem_m[addr[p]];
        tg[p] = (nw > 1) ? "R8" : (nw > 0) ? "R7" : phase_tag;
      end else if (sel_n[p]) tg[p] = "R5";
      else if (!wr_n[p])     tg[p] = "R6";
      else                   tg[p] = "R5";
    end
    @(posedge clk);
    for (int q = N - 1; q >= 0; q--) if (we[q]) mem_m[addr[q]] = int'(wdata[q]);
    #1;
    for (int p = 0; p < N; p++) begin
      check(tg[p], int'(rvalid[p]), int'(e_val[p]), $sformatf("port%0d valid", p));
      check(tg[p], int'(rdata[p]), e_data[p], $sformatf("port%0d data", p));
      check("R9", int'(clash[p]), int'(e_clash[p]), $sformatf("port%0d clash", p));
    end
  endtask

  initial begin
    idle_all();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(rvalid), 0, "valid in reset");
    check("R1", int'(clash), 0, "clash in reset");
    check("R1", int'(rdata), 0, "data in reset");
    rst = 1'b0;
    cycle();

    // fill every location, four per cycle
    phase_tag = "R2";
    for (int i = 0; i < DEPTH / N; i++) begin
      for (int p = 0; p < N; p++) set_port(p, 0, 0, 1, 1, i * N + p, ((i * N + p) * 7 + 3) & 255);
      cycle();
    end
    for (int i = 0; i < DEPTH / N; i++) begin
      for (int p = 0; p < N; p++) set_port(p, 0, 1, 0, 1, i * N + p, 0);
      cycle();
    end

    // held write, with a same-cycle reader expecting old data
    phase_tag = "R3";
    idle_all();
    set_port(0, 0, 0, 1, 0, 5, 8'hAA);
    set_port(1, 0, 1, 0, 1, 5, 0);
    cycle();
    for (int p = 0; p < N; p++) set_port(p, 0, 1, 0, 1, 5, 0);
    cycle();

    // deselected strobe must not write; disabled output must not drive
    phase_tag = "R5";
    idle_all();
    set_port(2, 1, 0, 0, 1, 6, 8'h55);
    set_port(3, 0, 1, 1, 1, 6, 0);
    cycle();
    idle_all();
    set_port(1, 0, 1, 0, 1, 6, 0);
    cycle();

    // single forwarded write
    phase_tag = "R7";
    idle_all();
    set_port(0, 0, 0, 0, 1, 10, 8'h11);
    set_port(2, 0, 1, 0, 1, 10, 0);
    cycle();

    // two writers clash, lowest wins
    phase_tag = "R8";
    idle_all();
    set_port(1, 0, 0, 1, 1, 20, 8'h22);
    set_port(3, 0, 0, 1, 1, 20, 8'h33);
    set_port(0, 0, 1, 0, 1, 20, 0);
    cycle();
    idle_all();
    set_port(3, 0, 1, 0, 1, 20, 0);
    cycle();

    // clash with one writer held: no flags
    phase_tag = "R9";
    idle_all();
    set_port(0, 0, 0, 1, 1, 30, 8'h44);
    set_port(1, 0, 0, 1, 0, 30, 8'h99);
    cycle();
    idle_all();
    set_port(2, 0, 1, 0, 1, 30, 0);
    cycle();

    // mixed traffic on a small address window
    phase_tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < N; p++)
        set_port(p, ($urandom % 6) == 0, ($urandom % 2) == 1, ($urandom % 5) == 0,
                 ($urandom % 5) != 0, int'($urandom % 12), int'($urandom % 256));
      cycle();
    end

    idle_all();
    cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule